// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen general registers of a processor core that runs in several operating modes. A few of those registers have separate physical copies for particular modes. A 5-bit mode code selects which copies are visible. Two combinational read ports and one write port address registers by a 4-bit number, and always act on the copies that belong to the current mode. A mode-change request names the next mode. In one clock edge the block parks the outgoing mode's private copies in backing storage and brings the incoming mode's copies into the live set.

A side port lets a debugger or an exception sequencer read or write a register as it appears from any mode. If the mode it names maps to the current bank, the access reaches the live register. If it names another bank, the access reaches that bank's stored copy.

The fast-interrupt bank privately owns registers 8 to 14. The interrupt, supervisor, abort and undefined banks own only registers 13 and 14. Codes with no defined mode fall to a dummy bank whose private registers start at zero every time it is entered.

Top module: `banked_regfile`

## Requirements
- R1: The mode code maps to a bank as follows: 0 and 16 give user; 1 and 17 give fast-interrupt; 2 and 18 give interrupt; 3 and 19 give supervisor; 23 gives abort; 27 gives undefined; 31 gives system. Any other code of the 32 gives the dummy bank.
- R2: The fast-interrupt bank has private copies of registers 8 to 14. Writes made there do not disturb the copies seen from any other bank, and writes made elsewhere do not disturb its copies.
- R3: The interrupt, supervisor, abort and undefined banks each have private copies of registers 13 and 14. They see the user copies of registers 8 to 12.
- R4: A mode change whose old and new codes map to the same bank leaves every register value unchanged.
- R5: The user copies of registers 8 to 12 survive a visit to the fast-interrupt bank. They are set aside on entry and brought back when any narrow bank is entered again.
- R6: On entry to the dummy bank from another bank, registers 8 to 14 read as zero. Whatever is written to them there is discarded when the bank is left, so the next entry reads zero again.
- R7: A side-port read or write whose mode maps to the current bank acts on the live register. One whose mode maps to another bank acts on that bank's stored copy. Registers 0 to 7 and 15 are common to all banks.
- R8: System mode shares every register with user mode.
- R9: Register 15 is never banked, and a mode change leaves its value unchanged.
- R10: A mode change takes effect at the next clock edge. Reads in the request cycle return the old mode's view. A write in the request cycle lands in the old mode's copy. When both write ports hit the same physical register in one cycle, the main port wins.
- R11: After reset all registers and stored copies hold zero and the current mode equals RESET_MODE (16 by default).
- R12: A side-port write naming the dummy bank while another bank is current does not change registers 8 to 14. A side-port read of those registers in that case returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_chg | input | 1 | Request to switch to mode_new at the next edge |
| mode_new | input | 5 | Code of the requested mode |
| cur_mode | output | 5 | Current mode code |
| rd_addr_a | input | 4 | Register number, read port A |
| rd_data_a | output | DATA_W | Read port A data, current-mode view |
| rd_addr_b | input | 4 | Register number, read port B |
| rd_data_b | output | DATA_W | Read port B data, current-mode view |
| wr_en | input | 1 | Main write enable |
| wr_addr | input | 4 | Main write register number |
| wr_data | input | DATA_W | Main write data |
| side_en | input | 1 | Side-port access enable |
| side_we | input | 1 | Side-port write (with side_en) |
| side_mode | input | 5 | Mode whose view the side port uses |
| side_addr | input | 4 | Side-port register number |
| side_wdata | input | DATA_W | Side-port write data |
| side_rdata | output | DATA_W | Side-port read data, zero when side_en is low |

## Verification
The bench builds the block with DATA_W of 32 and RESET_MODE of 16. This lets it check the reset view against user mode and use full-width patterns that tell the stored copies of every bank apart. Random stimulus draws mode codes from all 32 values, so undefined codes, the duplicate codes of each bank and system mode are all reached. Directed sequences cover the fast-interrupt round trip, same-bank switches, repeated dummy entries and side-port accesses to banks other than the current one. Side-port and main-port writes land in the same cycle as mode changes, which brings the old-view write rule and the write-port priority within reach.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    // Bank identifiers; the numeric value indexes narrow-bank storage.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_SYS = 3'd6,
        BK_DUM = 3'd7
    } bank_e;

    // Where a side-port access lands.
    typedef enum logic [2:0] {
        TG_LIVE = 3'd0,
        TG_FIQ  = 3'd1,
        TG_UHI  = 3'd2,
        TG_B13  = 3'd3,
        TG_B14  = 3'd4,
        TG_NONE = 3'd5
    } target_e;

    // System shares all storage with user.
    function automatic bank_e phys_bank(bank_e b);
        return (b == BK_SYS) ? BK_USR : b;
    endfunction

    // Wide banks own registers 8..14 privately.
    function automatic logic is_wide(bank_e b);
        return (b == BK_FIQ) || (b == BK_DUM);
    endfunction

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import banked_regfile_pkg::*;
#(
    parameter int MODE_W = 5
) (
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);
    always_comb begin
        case (mode_i)
            5'd0,  5'd16: bank_o = BK_USR;
            5'd1,  5'd17: bank_o = BK_FIQ;
            5'd2,  5'd18: bank_o = BK_IRQ;
            5'd3,  5'd19: bank_o = BK_SVC;
            5'd23:        bank_o = BK_ABT;
            5'd27:        bank_o = BK_UND;
            5'd31:        bank_o = BK_SYS;
            default:      bank_o = BK_DUM;
        endcase
    end
endmodule

// File: rtl/rf_side_route.sv
module rf_side_route
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NREG    = 16,
    parameter int UHI_N   = 5,
    parameter int FIQ_N   = 7,
    parameter int SLOT_N  = 6
) (
    input  bank_e             cur_bank,
    input  bank_e             side_bank,
    input  logic [3:0]        side_addr,
    input  logic [DATA_W-1:0] live   [NREG],
    input  logic [DATA_W-1:0] usr_hi [UHI_N],
    input  logic [DATA_W-1:0] fiq_st [FIQ_N],
    input  logic [DATA_W-1:0] b13_st [SLOT_N],
    input  logic [DATA_W-1:0] b14_st [SLOT_N],
    output target_e           tgt_o,
    output logic [DATA_W-1:0] rdata_o
);
    bank_e cur_p;
    bank_e side_p;
    logic  banked_reg;
    logic  low_shared;

    assign cur_p      = phys_bank(cur_bank);
    assign side_p     = phys_bank(side_bank);
    assign banked_reg = (side_addr >= 4'd8) && (side_addr <= 4'd14);
    assign low_shared = (side_addr <= 4'd12);

    always_comb begin
        if (!banked_reg || side_p == cur_p) begin
            tgt_o = TG_LIVE;
        end else if (side_p == BK_DUM) begin
            tgt_o = TG_NONE;
        end else if (side_p == BK_FIQ) begin
            tgt_o = TG_FIQ;
        end else if (low_shared) begin
            tgt_o = is_wide(cur_p) ? TG_UHI : TG_LIVE;
        end else begin
            tgt_o = (side_addr == 4'd13) ? TG_B13 : TG_B14;
        end
    end

    always_comb begin
        case (tgt_o)
            TG_LIVE: rdata_o = live[side_addr];
            TG_FIQ:  rdata_o = fiq_st[side_addr[2:0]];
            TG_UHI:  rdata_o = usr_hi[side_addr[2:0]];
            TG_B13:  rdata_o = b13_st[side_p];
            TG_B14:  rdata_o = b14_st[side_p];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [4:0]  RESET_MODE = 5'd16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg,
    input  logic [4:0]        mode_new,
    output logic [4:0]        cur_mode,
    input  logic [3:0]        rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              side_en,
    input  logic              side_we,
    input  logic [4:0]        side_mode,
    input  logic [3:0]        side_addr,
    input  logic [DATA_W-1:0] side_wdata,
    output logic [DATA_W-1:0] side_rdata
);
    localparam int NREG    = 16;
    localparam int BK_LO   = 8;
    localparam int SH_HI   = 12;
    localparam int BK_HI   = 14;
    localparam int UHI_N   = SH_HI - BK_LO + 1;
    localparam int FIQ_N   = BK_HI - BK_LO + 1;
    localparam int SLOT_N  = 6;
    localparam int NDEC    = 3;

    typedef struct {
        logic [4:0]        mode;
        logic [DATA_W-1:0] live   [NREG];
        logic [DATA_W-1:0] usr_hi [UHI_N];
        logic [DATA_W-1:0] fiq_st [FIQ_N];
        logic [DATA_W-1:0] b13_st [SLOT_N];
        logic [DATA_W-1:0] b14_st [SLOT_N];
    } state_t;

    state_t  st_d, st_q;

    // Three decoders: current, requested and side-port mode.
    logic [4:0] dec_mode [NDEC];
    bank_e      dec_bank [NDEC];
    bank_e      cur_bank_q, new_bank_d, side_bank_d;

    assign dec_mode[0] = st_q.mode;
    assign dec_mode[1] = mode_new;
    assign dec_mode[2] = side_mode;

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        rf_mode_decode #(.MODE_W(5)) u_dec (
            .mode_i (dec_mode[g]),
            .bank_o (dec_bank[g])
        );
    end

    assign cur_bank_q  = dec_bank[0];
    assign new_bank_d  = dec_bank[1];
    assign side_bank_d = dec_bank[2];

    target_e           side_tgt;
    logic [DATA_W-1:0] side_view;

    rf_side_route #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .UHI_N  (UHI_N),
        .FIQ_N  (FIQ_N),
        .SLOT_N (SLOT_N)
    ) u_side (
        .cur_bank  (cur_bank_q),
        .side_bank (side_bank_d),
        .side_addr (side_addr),
        .live      (st_q.live),
        .usr_hi    (st_q.usr_hi),
        .fiq_st    (st_q.fiq_st),
        .b13_st    (st_q.b13_st),
        .b14_st    (st_q.b14_st),
        .tgt_o     (side_tgt),
        .rdata_o   (side_view)
    );

    // Reads always show the registered (pre-switch) view.
    assign rd_data_a  = st_q.live[rd_addr_a];
    assign rd_data_b  = st_q.live[rd_addr_b];
    assign side_rdata = side_en ? side_view : '0;
    assign cur_mode   = st_q.mode;

    bank_e old_p, new_p;
    assign old_p = phys_bank(cur_bank_q);
    assign new_p = phys_bank(new_bank_d);

    always_comb begin
        st_d = st_q;

        // Side-port write first, so the main port wins on a collision.
        if (side_en && side_we) begin
            case (side_tgt)
                TG_LIVE: st_d.live[side_addr]           = side_wdata;
                TG_FIQ:  st_d.fiq_st[side_addr[2:0]]    = side_wdata;
                TG_UHI:  st_d.usr_hi[side_addr[2:0]]    = side_wdata;
                TG_B13:  st_d.b13_st[phys_bank(side_bank_d)] = side_wdata;
                TG_B14:  st_d.b14_st[phys_bank(side_bank_d)] = side_wdata;
                default: ;
            endcase
        end

        // Main write lands in the old mode's view.
        if (wr_en) begin
            st_d.live[wr_addr] = wr_data;
        end

        if (mode_chg) begin
            st_d.mode = mode_new;
            if (old_p != new_p) begin
                // Park outgoing private copies.
                case (old_p)
                    BK_FIQ: begin
                        for (int i = 0; i < FIQ_N; i++) begin
                            st_d.fiq_st[i] = st_d.live[BK_LO+i];
                        end
                    end
                    BK_DUM: ;
                    default: begin
                        st_d.b13_st[old_p] = st_d.live[13];
                        st_d.b14_st[old_p] = st_d.live[14];
                        if (is_wide(new_p)) begin
                            for (int i = 0; i < UHI_N; i++) begin
                                st_d.usr_hi[i] = st_d.live[BK_LO+i];
                            end
                        end
                    end
                endcase
                // Bring in incoming copies.
                case (new_p)
                    BK_FIQ: begin
                        for (int i = 0; i < FIQ_N; i++) begin
                            st_d.live[BK_LO+i] = st_d.fiq_st[i];
                        end
                    end
                    BK_DUM: begin
                        for (int i = 0; i < FIQ_N; i++) begin
                            st_d.live[BK_LO+i] = '0;
                        end
                    end
                    default: begin
                        st_d.live[13] = st_d.b13_st[new_p];
                        st_d.live[14] = st_d.b14_st[new_p];
                        if (is_wide(old_p)) begin
                            for (int i = 0; i < UHI_N; i++) begin
                                st_d.live[BK_LO+i] = st_d.usr_hi[i];
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= RESET_MODE;
            for (int i = 0; i < NREG; i++)   st_q.live[i]   <= '0;
            for (int i = 0; i < UHI_N; i++)  st_q.usr_hi[i] <= '0;
            for (int i = 0; i < FIQ_N; i++)  st_q.fiq_st[i] <= '0;
            for (int i = 0; i < SLOT_N; i++) begin
                st_q.b13_st[i] <= '0;
                st_q.b14_st[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    logic [DATA_W-1:0] pc_q, r8_q, r13_q;
    logic              hi_nonzero;
    logic              pc_written, any_write;

    assign pc_q       = st_q.live[15];
    assign r8_q       = st_q.live[8];
    assign r13_q      = st_q.live[13];
    assign hi_nonzero = |{st_q.live[8], st_q.live[9], st_q.live[10], st_q.live[11],
                          st_q.live[12], st_q.live[13], st_q.live[14]};
    assign pc_written = (wr_en && wr_addr == 4'd15) ||
                        (side_en && side_we && side_addr == 4'd15);
    assign any_write  = wr_en || (side_en && side_we);

    a_r10_switch_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> cur_mode == $past(mode_new));

    a_r10_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |=> $stable(cur_mode));

    a_r9_pc_unbanked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !pc_written) |=> $stable(pc_q));

    a_r6_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && new_p == BK_DUM && old_p != BK_DUM) |=> !hi_nonzero);

    a_r4_same_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && new_p == old_p && !any_write) |=> ($stable(r8_q) && $stable(r13_q)));

    a_r12_side_dummy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (side_en && side_tgt == TG_NONE) |-> side_rdata == '0);

endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_chg = 1'b0;
    logic [4:0]    mode_new = '0;
    logic [4:0]    cur_mode;
    logic [3:0]    rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0, side_addr = '0;
    logic [DW-1:0] rd_data_a, rd_data_b, side_rdata;
    logic          wr_en = 1'b0, side_en = 1'b0, side_we = 1'b0;
    logic [DW-1:0] wr_data = '0, side_wdata = '0;
    logic [4:0]    side_mode = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    banked_regfile #(.DATA_W(DW), .RESET_MODE(5'd16)) u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode_chg(mode_chg), .mode_new(mode_new),
        .cur_mode(cur_mode), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .side_en(side_en),
        .side_we(side_we), .side_mode(side_mode), .side_addr(side_addr),
        .side_wdata(side_wdata), .side_rdata(side_rdata)
    );

    // ---------- reference model built from the requirements ----------
    logic [DW-1:0] mem [64];
    int            cur_b;
    logic [4:0]    cur_m;

    // R1 decode table: 0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,6 sys,7 dummy
    function automatic int b_of(int m);
        case (m)
            0, 16: return 0;
            1, 17: return 1;
            2, 18: return 2;
            3, 19: return 3;
            23:    return 4;
            27:    return 5;
            31:    return 6;
            default: return 7;
        endcase
    endfunction

    function automatic int pb(int b);
        return (b == 6) ? 0 : b;   // R8
    endfunction

    function automatic int loc(int b, int r);
        int p = pb(b);
        if (r < 8 || r == 15) return r;
        if (p == 1) return 24 + r - 8;
        if (p == 7) return 32 + r - 8;
        if (r <= 12) return 16 + r - 8;
        return 40 + 2 * p + (r - 13);
    endfunction

    function automatic logic blocked(int b, int r);
        return pb(b) == 7 && pb(cur_b) != 7 && r >= 8 && r <= 14;
    endfunction

    function automatic logic [DW-1:0] model_rd(int b, int r);
        if (blocked(b, r)) return '0;
        return mem[loc(b, r)];
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check before posedge, update model at edge.
    task automatic cyc(bit mc, int nm, bit we, int wa, logic [DW-1:0] wd,
                       int ra, int rb, bit se, bit sw, int sm, int sa,
                       logic [DW-1:0] sd, string tag);
        mode_chg = mc; mode_new = nm[4:0];
        wr_en = we; wr_addr = wa[3:0]; wr_data = wd;
        rd_addr_a = ra[3:0]; rd_addr_b = rb[3:0];
        side_en = se; side_we = sw; side_mode = sm[4:0];
        side_addr = sa[3:0]; side_wdata = sd;
        #1;
        chk(tag, "rd_a", rd_data_a, model_rd(cur_b, ra));
        chk(tag, "rd_b", rd_data_b, model_rd(cur_b, rb));
        chk("R10", "cur_mode", {27'd0, cur_mode}, {27'd0, cur_m});
        if (se && !sw) chk(tag, "side_rdata", side_rdata, model_rd(b_of(sm), sa));
        @(posedge clk);
        if (se && sw && !blocked(b_of(sm), sa)) mem[loc(b_of(sm), sa)] = sd;
        if (we) mem[loc(cur_b, wa)] = wd;
        if (mc) begin
            if (b_of(nm) == 7 && cur_b != 7)
                for (int i = 32; i < 39; i++) mem[i] = '0;
            cur_b = b_of(nm);
            cur_m = nm[4:0];
        end
        @(negedge clk);
    endtask

    task automatic idle_rd(int ra, int rb, string tag);
        cyc(0, 0, 0, 0, '0, ra, rb, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) idle_rd(2 * i, 2 * i + 1, tag);
    endtask

    task automatic sw_mode(int m, string tag);
        cyc(1, m, 0, 0, '0, 8, 13, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic wr(int r, logic [DW-1:0] v, string tag);
        cyc(0, 0, 1, r, v, r, 15, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic side_rd(int m, int r, string tag);
        cyc(0, 0, 0, 0, '0, 0, 0, 1, 0, m, r, '0, tag);
    endtask

    task automatic side_wr(int m, int r, logic [DW-1:0] v, string tag);
        cyc(0, 0, 0, 0, '0, 0, 0, 1, 1, m, r, v, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        cur_b = 0; cur_m = 5'd16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "reset mode", {27'd0, cur_mode}, 32'd16);
        check_all("R11");

        // User fill, then user -> FIQ -> IRQ -> user
        for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 + i, "R7");
        check_all("R7");
        sw_mode(17, "R2");
        check_all("R2");
        for (int i = 8; i < 15; i++) wr(i, 32'hF1F0_0000 + i, "R2");
        check_all("R9");
        sw_mode(18, "R5");
        check_all("R5");
        wr(13, 32'h1A1A_0013, "R3"); wr(14, 32'h1A1A_0014, "R3");
        wr(9, 32'h5A5A_0009, "R3");
        sw_mode(16, "R3");
        check_all("R3");
        sw_mode(1, "R2");
        check_all("R2");
        sw_mode(19, "R5");
        check_all("R5");

        // Same bank / system sharing
        sw_mode(0, "R4");
        check_all("R4");
        sw_mode(16, "R4");
        sw_mode(31, "R8");
        check_all("R8");
        wr(14, 32'h5E5E_0014, "R8");
        sw_mode(16, "R8");
        check_all("R8");

        // R10: reads and write in the switch cycle use the old view
        cyc(1, 17, 1, 10, 32'hAB_0010, 10, 14, 0, 0, 0, 0, '0, "R10");
        check_all("R10");
        cyc(1, 16, 1, 12, 32'hAB_F012, 12, 8, 1, 1, 16, 12, 32'hDEAD_0012, "R10");
        check_all("R10");
        cyc(0, 0, 1, 3, 32'hC0C0_0003, 3, 3, 1, 1, 17, 3, 32'hBAD0_0003, "R10");
        idle_rd(3, 4, "R10");

        // R6 dummy bank
        sw_mode(4, "R6");
        check_all("R6");
        wr(8, 32'h0D0D_0008, "R6"); wr(14, 32'h0D0D_0014, "R6");
        idle_rd(8, 14, "R6");
        sw_mode(16, "R6");
        check_all("R6");
        sw_mode(20, "R6");
        check_all("R6");
        sw_mode(16, "R6");

        // R7 / R12 side port
        side_rd(17, 10, "R7"); side_rd(18, 13, "R7"); side_rd(16, 9, "R7");
        side_rd(31, 14, "R7"); side_rd(19, 2, "R7");
        side_wr(3, 14, 32'h5C5C_AAAA, "R7");
        side_wr(17, 8, 32'hF8F8_0008, "R7");
        side_rd(3, 14, "R7");
        sw_mode(3, "R7");
        check_all("R7");
        side_wr(9, 8, 32'hBADD_0008, "R12");
        side_rd(9, 8, "R12");
        sw_mode(9, "R12");
        check_all("R12");
        sw_mode(16, "R12");

        // R1: walk every code
        for (int m = 0; m < 32; m++) begin
            sw_mode(m, "R1");
            wr(13, 32'hC0DE_0000 + m, "R1");
            wr(9, 32'h9900_0000 + m, "R1");
            idle_rd(13, 9, "R1");
        end
        sw_mode(16, "R1");
        check_all("R1");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            bit mc = ($urandom % 6) == 0;
            bit se = $urandom % 2;
            cyc(mc, $urandom % 32, $urandom % 2, $urandom % 16, $urandom,
                $urandom % 16, $urandom % 16, se, se && (($urandom % 3) == 0),
                $urandom % 32, $urandom % 16, $urandom, "R7");
        end
        for (int m = 0; m < 32; m++) begin
            sw_mode(m, "R1");
            check_all("R1");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule